// File: doc/BRIEF.md
# Hardware Thread Fetch Selector

This block decides, every cycle, which of a small set of hardware threads (two to four) feeds the fetch stage of a multithreaded core. The surrounding core supplies the per-thread status it needs. That status is a ready flag, which a thread waiting on an instruction-cache miss holds low for the miss latency. It also includes a long-latency event flag and three occupancy counts: in-flight instructions, in-flight branches and outstanding misses. The block answers in the same cycle with a one-hot grant and a valid bit. Changing the granted thread costs no cycles.

A three-bit mode selects the scheduling policy:
- Coarse switching stays on one thread until it raises an expensive event.
- Fine rotation changes thread each cycle among the ready threads.
- Burst rotation gives each thread a configurable number of consecutive grants.
- Three least-loaded modes favour the ready thread with the smallest branch, miss or instruction count.

A rotating priority pointer breaks ties and orders every search. A per-thread wait counter forces a grant to any thread that has been ready but passed over for a programmable number of cycles, in every mode.

Mode and burst-length inputs are copied into the active setting only when no burst is in progress. A running burst is therefore never cut short.

Top module: `thread_fetch_sel`

## Requirements
- R1: Whenever at least one thread is ready, valid_o is 1 and grant_o has exactly one bit set, and that bit belongs to a ready thread. With no thread ready, valid_o is 0 and grant_o is all zeros.
- R2: While rst_n is low, valid_o and grant_o are 0. After reset, the active mode is coarse (code 0), the burst length is 1, the current thread is 0 and the pointer is 0, so the first grant with all threads ready goes to thread 0.
- R3: In coarse mode (code 0), the current thread keeps the grant while it is ready. If the current thread has event_i set and another thread is ready, the grant moves to the first other ready thread found from the pointer upward, with wraparound.
- R4: In fine mode (code 1, and likewise unused codes 6 and 7), the grant goes to the first ready thread at or after the pointer. With two or more threads ready, consecutive grants therefore always differ.
- R5: In burst mode (code 2), a thread granted at a burst start keeps the grant for the active burst length of consecutive cycles, as long as it stays ready. A burst length of 0 acts as 1. When the burst ends or is broken, the next grant goes to the first ready thread from the pointer.
- R6: In mode 3, the grant goes to the ready thread with the smallest in-flight branch count.
- R7: In mode 4, the grant goes to the ready thread with the smallest outstanding-miss count.
- R8: In mode 5, the grant goes to the ready thread with the smallest in-flight instruction count. In modes 3, 4 and 5, equal counts are resolved in favour of the thread met first when searching from the pointer upward.
- R9: After each valid grant to thread g, the pointer becomes g+1, modulo the thread count. In a cycle with no valid grant, the pointer, the current thread and the burst position keep their values, except that the burst is abandoned.
- R10: A wait counter counts the consecutive cycles a thread is ready but not granted. When starve_lim_i is non-zero and one or more ready threads have counters at or above it, the grant goes to the first such thread from the pointer, overriding the mode. A forced grant ends any burst.
- R11: mode_i and burst_i are copied into the active setting only at a clock edge after which no burst is in progress. A change made mid-burst takes effect in the cycle after the burst's last grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Requested policy code |
| burst_i | input | BW | Requested burst length for burst mode |
| starve_lim_i | input | SW | Wait limit before a forced grant (0 disables) |
| ready_i | input | NT | Per-thread ready flags |
| event_i | input | NT | Per-thread expensive-event flags |
| infl_insn_i | input | NT*CW | Per-thread in-flight instruction counts, thread i at bits [i*CW +: CW] |
| infl_br_i | input | NT*CW | Per-thread in-flight branch counts, same packing |
| miss_cnt_i | input | NT*CW | Per-thread outstanding miss counts, same packing |
| grant_o | output | NT | One-hot thread grant |
| valid_o | output | 1 | Grant is meaningful |

## Verification
The bench forces a mode change in the middle of a two-cycle burst. A selector that reloads its mode too early would switch to fine rotation one cycle too soon and grant a different thread. It also feeds equal counts in the least-loaded modes. A design that broke ties by thread index instead of by the pointer would then grant the same thread repeatedly instead of rotating.

Cycles with no ready thread are followed by a full ready set, which catches a pointer that drifts while idle. A coarse run with every thread ready and no events must be broken up by the wait limit. Without that, thread 0 would keep the grant forever.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
    typedef enum logic [2:0] {
        M_COARSE = 3'd0,
        M_FINE   = 3'd1,
        M_BURST  = 3'd2,
        M_LBR    = 3'd3,
        M_LMISS  = 3'd4,
        M_LINSN  = 3'd5
    } tfs_mode_e;
endpackage

// File: rtl/tfs_pick.sv
// First set bit of a mask, searching upward from a start index with wraparound.
module tfs_pick #(
    parameter int NT = 4,
    parameter int TW = $clog2(NT)
) (
    input  logic [NT-1:0] mask_i,
    input  logic [TW-1:0] ptr_i,
    output logic          found_o,
    output logic [TW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // walk the rotation backwards so the earliest hit is the last one written
        for (int k = NT - 1; k >= 0; k--) begin
            int j;
            j = int'(ptr_i) + k;
            if (j >= NT) j = j - NT;
            if (mask_i[j]) begin
                found_o = 1'b1;
                idx_o   = TW'(j);
            end
        end
    end
endmodule

// File: rtl/tfs_minsel.sv
// Smallest metric among masked threads; ties go to the earliest in rotation order.
module tfs_minsel #(
    parameter int NT = 4,
    parameter int CW = 4,
    parameter int TW = $clog2(NT)
) (
    input  logic [NT-1:0]    mask_i,
    input  logic [NT*CW-1:0] metric_i,
    input  logic [TW-1:0]    ptr_i,
    output logic             found_o,
    output logic [TW-1:0]    idx_o
);
    logic [CW-1:0] best;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int k = 0; k < NT; k++) begin
            int j;
            j = int'(ptr_i) + k;
            if (j >= NT) j = j - NT;
            if (mask_i[j] && (!found_o || (metric_i[j*CW +: CW] < best))) begin
                found_o = 1'b1;
                idx_o   = TW'(j);
                best    = metric_i[j*CW +: CW];
            end
        end
    end
endmodule

// File: rtl/tfs_starve.sv
// Per-thread wait counters and the forced-grant request mask.
module tfs_starve #(
    parameter int NT = 4,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] ready_i,
    input  logic [NT-1:0] grant_i,
    input  logic [SW-1:0] lim_i,
    output logic [NT-1:0] force_o
);
    localparam logic [SW-1:0] CMAX = {SW{1'b1}};

    for (genvar i = 0; i < NT; i++) begin : g_thr
        logic [SW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = '0;
            if (ready_i[i] && !grant_i[i]) begin
                cnt_d = (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign force_o[i] = ready_i[i] && (lim_i != '0) && (cnt_q >= lim_i);

        // R10: a thread granted in one cycle cannot be among the starved the next
        a_r10_grant_clears: assert property (@(posedge clk) disable iff (!rst_n)
            grant_i[i] |=> !force_o[i]);
    end
endmodule

// File: rtl/thread_fetch_sel.sv
module thread_fetch_sel
    import tfs_pkg::*;
#(
    parameter int NT = 4,
    parameter int CW = 4,
    parameter int BW = 3,
    parameter int SW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      mode_i,
    input  logic [BW-1:0]   burst_i,
    input  logic [SW-1:0]   starve_lim_i,
    input  logic [NT-1:0]   ready_i,
    input  logic [NT-1:0]   event_i,
    input  logic [NT*CW-1:0] infl_insn_i,
    input  logic [NT*CW-1:0] infl_br_i,
    input  logic [NT*CW-1:0] miss_cnt_i,
    output logic [NT-1:0]   grant_o,
    output logic            valid_o
);
    localparam int TW = $clog2(NT);
    localparam logic [TW-1:0] LAST = TW'(NT - 1);
    localparam logic [NT-1:0] ONE  = {{(NT-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [TW-1:0] cur;
        logic [TW-1:0] ptr;
        logic [BW-1:0] bcnt;
        tfs_mode_e     mode;
        logic [BW-1:0] burst;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [NT-1:0]    force_w, other_w;
    logic [NT*CW-1:0] metric_w;
    logic             a_found, o_found, f_found, m_found;
    logic [TW-1:0]    a_idx, o_idx, f_idx, m_idx;
    logic [TW-1:0]    g;
    logic             any_rdy, forced;
    logic [BW-1:0]    eff_burst, cntn;

    assign other_w  = ready_i & ~(ONE << st_q.cur);
    assign metric_w = (st_q.mode == M_LBR)   ? infl_br_i  :
                      (st_q.mode == M_LMISS) ? miss_cnt_i : infl_insn_i;

    tfs_pick #(.NT(NT), .TW(TW)) u_pick_all (
        .mask_i(ready_i), .ptr_i(st_q.ptr), .found_o(a_found), .idx_o(a_idx));
    tfs_pick #(.NT(NT), .TW(TW)) u_pick_oth (
        .mask_i(other_w), .ptr_i(st_q.ptr), .found_o(o_found), .idx_o(o_idx));
    tfs_pick #(.NT(NT), .TW(TW)) u_pick_frc (
        .mask_i(force_w), .ptr_i(st_q.ptr), .found_o(f_found), .idx_o(f_idx));
    tfs_minsel #(.NT(NT), .CW(CW), .TW(TW)) u_minsel (
        .mask_i(ready_i), .metric_i(metric_w), .ptr_i(st_q.ptr),
        .found_o(m_found), .idx_o(m_idx));

    tfs_starve #(.NT(NT), .SW(SW)) u_starve (
        .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .grant_i(grant_o),
        .lim_i(starve_lim_i), .force_o(force_w));

    always_comb begin
        st_d      = st_q;
        any_rdy   = a_found;
        forced    = f_found;
        g         = st_q.cur;
        eff_burst = (st_q.burst == '0) ? BW'(1) : st_q.burst;
        cntn      = BW'(1);

        if (forced) begin
            g = f_idx;
        end else begin
            case (st_q.mode)
                M_COARSE: begin
                    if (ready_i[st_q.cur] && (!event_i[st_q.cur] || !o_found)) g = st_q.cur;
                    else                                                      g = o_idx;
                end
                M_BURST: begin
                    if ((st_q.bcnt != '0) && ready_i[st_q.cur]) g = st_q.cur;
                    else                                         g = a_idx;
                end
                M_LBR, M_LMISS, M_LINSN: g = m_found ? m_idx : a_idx;
                default: g = a_idx;
            endcase
        end

        if (any_rdy) begin
            st_d.cur = g;
            st_d.ptr = (g == LAST) ? '0 : g + 1'b1;
            if ((st_q.mode == M_BURST) && !forced) begin
                if ((g == st_q.cur) && (st_q.bcnt != '0)) cntn = st_q.bcnt + 1'b1;
                st_d.bcnt = (cntn >= eff_burst) ? '0 : cntn;
            end else begin
                st_d.bcnt = '0;
            end
        end else begin
            st_d.bcnt = '0;
        end

        // settings reload only where no burst continues past this edge
        if (st_d.bcnt == '0) begin
            st_d.mode  = tfs_mode_e'(mode_i);
            st_d.burst = burst_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cur   <= '0;
            st_q.ptr   <= '0;
            st_q.bcnt  <= '0;
            st_q.mode  <= M_COARSE;
            st_q.burst <= BW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = rst_n && any_rdy;
    assign grant_o = valid_o ? (ONE << g) : '0;

    // R1: one grant bit whenever any thread is ready
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (|ready_i) |-> ($countones(grant_o) == 1));
    // R1: a grant never lands on a stalled thread
    a_r1_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~ready_i) == '0);
    // R9: an idle cycle leaves the rotation pointer alone
    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> $stable(st_q.ptr));
    // R4: fine rotation never repeats a thread while another is ready
    a_r4_fine_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && (st_q.mode == M_FINE) && ($countones(ready_i) > 1))
        |-> (grant_o != $past(grant_o)));
    // R10: a starved ready thread wins over the policy
    a_r10_force_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|force_w) |-> (|(grant_o & force_w)));
    // R11: settings stay frozen while a burst is running
    a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bcnt != '0) |-> ($stable(st_q.mode) && $stable(st_q.burst)));
endmodule

// File: tb/thread_fetch_sel_bench.sv
module thread_fetch_sel_bench;
    localparam int NT = 4;
    localparam int CW = 4;
    localparam int BW = 3;
    localparam int SW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      mode_i = '0;
    logic [BW-1:0]   burst_i = BW'(1);
    logic [SW-1:0]   lim_i = '0;
    logic [NT-1:0]   ready_i = '0;
    logic [NT-1:0]   event_i = '0;
    logic [NT*CW-1:0] insn_i = '0;
    logic [NT*CW-1:0] br_i = '0;
    logic [NT*CW-1:0] miss_i = '0;
    logic [NT-1:0]   grant_o;
    logic            valid_o;

    int checks = 0;
    int fails  = 0;

    // model of the active state, maintained from the requirements
    int m_cur, m_ptr, m_bcnt, m_mode, m_burst;
    int m_cnt [NT];

    always #5 clk = ~clk;

    thread_fetch_sel #(.NT(NT), .CW(CW), .BW(BW), .SW(SW)) u_thread_fetch_sel (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .burst_i(burst_i),
        .starve_lim_i(lim_i), .ready_i(ready_i), .event_i(event_i),
        .infl_insn_i(insn_i), .infl_br_i(br_i), .miss_cnt_i(miss_i),
        .grant_o(grant_o), .valid_o(valid_o));

    function automatic logic [NT*CW-1:0] pack4(int a, int b, int c, int d);
        return {CW'(d), CW'(c), CW'(b), CW'(a)};
    endfunction

    function automatic int first_from(logic [NT-1:0] m, int p);
        for (int k = 0; k < NT; k++) begin
            if (m[(p + k) % NT]) return (p + k) % NT;
        end
        return -1;
    endfunction

    function automatic int least_from(logic [NT-1:0] m, logic [NT*CW-1:0] v, int p);
        int best_i = -1;
        int best_v = 0;
        for (int k = 0; k < NT; k++) begin
            int j = (p + k) % NT;
            if (m[j] && (best_i < 0 || int'(v[j*CW +: CW]) < best_v)) begin
                best_i = j;
                best_v = int'(v[j*CW +: CW]);
            end
        end
        return best_i;
    endfunction

    function automatic logic [NT-1:0] starved();
        logic [NT-1:0] f = '0;
        for (int i = 0; i < NT; i++)
            if (lim_i != 0 && ready_i[i] && m_cnt[i] >= int'(lim_i)) f[i] = 1'b1;
        return f;
    endfunction

    function automatic int predict();
        logic [NT-1:0] f;
        logic [NT-1:0] oth;
        if (ready_i == '0) return -1;
        f = starved();
        if (f != '0) return first_from(f, m_ptr);
        oth = ready_i & ~(NT'(1) << m_cur);
        case (m_mode)
            0: if (ready_i[m_cur] && (!event_i[m_cur] || oth == '0)) return m_cur;
               else return first_from(oth, m_ptr);
            2: if (m_bcnt != 0 && ready_i[m_cur]) return m_cur;
               else return first_from(ready_i, m_ptr);
            3: return least_from(ready_i, br_i, m_ptr);
            4: return least_from(ready_i, miss_i, m_ptr);
            5: return least_from(ready_i, insn_i, m_ptr);
            default: return first_from(ready_i, m_ptr);
        endcase
    endfunction

    task automatic model_reset();
        m_cur = 0; m_ptr = 0; m_bcnt = 0; m_mode = 0; m_burst = 1;
        for (int i = 0; i < NT; i++) m_cnt[i] = 0;
    endtask

    task automatic model_step(int g);
        logic frc;
        int eb, cn;
        frc = (starved() != '0);
        for (int i = 0; i < NT; i++) begin
            if (ready_i[i] && i != g) m_cnt[i] = (m_cnt[i] >= 63) ? 63 : m_cnt[i] + 1;
            else                      m_cnt[i] = 0;
        end
        if (g >= 0) begin
            if (m_mode == 2 && !frc) begin
                eb = (m_burst == 0) ? 1 : m_burst;
                cn = (g == m_cur && m_bcnt != 0) ? m_bcnt + 1 : 1;
                m_bcnt = (cn >= eb) ? 0 : cn;
            end else begin
                m_bcnt = 0;
            end
            m_cur = g;
            m_ptr = (g + 1) % NT;
        end else begin
            m_bcnt = 0;
        end
        if (m_bcnt == 0) begin
            m_mode  = int'(mode_i);
            m_burst = int'(burst_i);
        end
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle: inputs already set after a falling edge; sample, then cross the rising edge
    task automatic step(string tag, int exp);
        int g;
        logic [NT-1:0] eg;
        #1;
        g  = predict();
        eg = (g < 0) ? '0 : (NT'(1) << g);
        check((valid_o == (g >= 0)) && (grant_o == eg), tag, {valid_o, grant_o}, {(g >= 0), eg});
        if (exp != -2) begin
            eg = (exp < 0) ? '0 : (NT'(1) << exp);
            check(grant_o == eg && valid_o == (exp >= 0), {tag, " directed"}, grant_o, eg);
        end
        model_step(g);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            ready_i = '1;
            #1;
            check(valid_o == 1'b0 && grant_o == '0, "R2 outputs low in reset", grant_o, 0);
        end
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        do_reset();
        mode_i = 3'd0; burst_i = BW'(1); lim_i = '0; ready_i = 4'b1111; event_i = '0;
        step("R2 first grant thread 0", 0);
        event_i = 4'b0001;
        step("R3 event moves grant", 1);
        event_i = '0;
        step("R3 current thread held", 1);
        event_i = 4'b0010; ready_i = 4'b1011;
        step("R3 next ready from pointer", 3);
        event_i = '0; ready_i = 4'b1111; mode_i = 3'd1;
        step("R3 coarse before reload", 3);
        step("R4 fine rotation a", 0);
        step("R4 fine rotation b", 1);
        step("R4 fine rotation c", 2);
        ready_i = 4'b0101;
        step("R4 fine skips stalled a", 0);
        step("R4 fine skips stalled b", 2);
        ready_i = '0;
        step("R1 no ready gives no grant", -1);
        step("R9 idle again", -1);
        ready_i = 4'b1111;
        step("R9 pointer held over idle", 3);
        mode_i = 3'd2; burst_i = BW'(2);
        step("R11 fine until reload", 0);
        step("R5 burst start", 1);
        step("R5 burst second grant", 1);
        step("R5 next burst start", 2);
        mode_i = 3'd1;
        step("R11 burst not split", 2);
        step("R11 fine after boundary a", 3);
        step("R11 fine after boundary b", 0);
        mode_i = 3'd3;
        step("R4 last fine grant", 1);
        br_i = pack4(3, 9, 1, 1); ready_i = 4'b1011; mode_i = 3'd4;
        step("R6 fewest branches", 3);
        ready_i = 4'b1111; miss_i = pack4(0, 4, 4, 4); mode_i = 3'd5;
        step("R7 fewest misses", 0);
        insn_i = pack4(6, 2, 5, 2);
        step("R8 fewest instructions tie a", 1);
        step("R8 tie rotates b", 3);
        step("R8 tie rotates c", 1);

        mode_i = 3'd0; lim_i = SW'(3); ready_i = 4'b1111; event_i = '0;
        do_reset();
        step("R10 coarse hold a", 0);
        step("R10 coarse hold b", 0);
        step("R10 coarse hold c", 0);
        step("R10 forced thread 1", 1);
        step("R10 forced thread 2", 2);
        step("R10 forced thread 3", 3);
        step("R10 forced thread 0", 0);

        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 19) == 0) begin
                mode_i  = 3'($urandom_range(0, 7));
                burst_i = BW'($urandom_range(0, 3));
            end
            if ($urandom_range(0, 99) == 0)
                lim_i = ($urandom_range(0, 2) == 0) ? '0 : SW'($urandom_range(2, 6));
            ready_i = NT'($urandom) | NT'($urandom);
            if ($urandom_range(0, 9) == 0) ready_i = '0;
            event_i = NT'($urandom) & NT'($urandom);
            insn_i  = pack4($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
            br_i    = pack4($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
            miss_i  = pack4($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
            step("R1 R3 R4 R5 R6 R7 R8 R9 R10 R11 random", -2);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule